// File: doc/BRIEF.md
# Dual-Bus External Program Fetch Sequencer

This block produces the external memory bus timing for an 8-bit controller core. A core cycle lasts twelve oscillator periods and holds two program fetch slots. A free-running phase counter sets the timing. Each slot drives an address-latch pulse, and then a read strobe on whichever of two multiplexed address/data port pairs holds the code. The primary pair also carries every external data read and write.

Two strap inputs choose the code bus. With the external-access strap low, the bus-select strap alone picks the pair for the whole 64K space. With both straps high, code below a parameterised boundary (default 2000H) comes from the secondary pair and the rest from the primary pair. Bus-select low with external-access high is an invalid setting and produces no fetch strobe. When the secondary pair is not the code bus, it works as two plain registered output ports.

The core presents a request at the end of each cycle: a fetch address, a data read or write flag, a 16-bit data address and write data. The block latches each returned opcode byte and flags it for one clock.

Top module: `dbfetch_seq`

## Requirements
- R1: The `phase` output counts 0 to 11 and wraps, advancing once per clock. Requests are captured at the clock edge that ends phase 11. Outside a data cycle `ale` is high in phases 0-1 and 6-7, which gives two pulses per core cycle.
- R2: In a fetch cycle the active program strobe is low in phases 2-4 for the fetch at the captured address and in phases 8-10 for the fetch at that address plus one. The low input byte of the pair in use is latched as `opcode`, and `opcode_vld` is high in phases 5 and 11.
- R3: In a data cycle (`data_rd` or `data_wr` captured high), `ale` is high only in phases 0-1 and neither program strobe goes low. `rd_n` or `wr_n` is low in phases 3-9. The primary low port drives the low byte of the data address with its enable high in phase 0. For a write it drives the write data with the enable high in phase 5; for a read the enable is low in phase 5.
- R4: With `bus_sel`=0 and `ext_acc`=0, every fetch uses the primary pair and `psen_pri_n`: the low address byte on `pri_lo_out` during the address-latch phases and the high byte on `pri_hi_out`. `psen_sec_n` stays high.
- R5: With `bus_sel`=1 and `ext_acc`=0, every fetch at any address uses the secondary pair and `psen_sec_n`, and `psen_pri_n` stays high.
- R6: With both straps high, each fetch is routed on its own. An address below 2000H uses the secondary pair; an address at or above it uses the primary pair. The fetch at 1FFFH and the following one at 2000H therefore split across the two pairs.
- R7: With `bus_sel`=0 and `ext_acc`=1, neither program strobe goes low and `opcode_vld` stays low.
- R8: Data accesses always use the primary pair. `pri_hi_out` carries the high data address byte, and `sec_lo_oe` stays low even when the secondary pair is the code bus.
- R9: With `bus_sel`=0, `sec_lo_out` and `sec_hi_out` show two registers loaded from `io_lo_d` and `io_hi_d` at a clock with `io_we` high, with `sec_lo_oe` high. Both registers reset to FFH.
- R10: While `rst` is high, `ale`, both program strobes, `rd_n` and `wr_n` are high and `phase` is 0. The first cycle after release fetches 0000H and then 0001H.
- R11: While `idle` is high, `ale`, both program strobes, `rd_n` and `wr_n` are high and no opcode is flagged. With `bus_sel`=1, `sec_hi_out` is FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Strap choosing the secondary pair for code |
| ext_acc | input | 1 | External-access strap |
| idle | input | 1 | Core sleeping; bus quiet |
| fetch_addr | input | 16 | Address of the first fetch of the next cycle |
| data_rd | input | 1 | Next cycle is a data read |
| data_wr | input | 1 | Next cycle is a data write |
| data_addr | input | 16 | Data address for the next cycle |
| wr_data | input | 8 | Write data for the next cycle |
| io_we | input | 1 | Load the secondary port registers |
| io_lo_d | input | 8 | New value for the secondary low port register |
| io_hi_d | input | 8 | New value for the secondary high port register |
| pri_lo_in | input | 8 | Byte read back on the primary low port |
| sec_lo_in | input | 8 | Byte read back on the secondary low port |
| phase | output | 4 | Phase within the core cycle |
| ale | output | 1 | Address latch enable |
| psen_pri_n | output | 1 | Program read strobe, primary pair |
| psen_sec_n | output | 1 | Program read strobe, secondary pair |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |
| pri_lo_out | output | 8 | Primary low port drive value |
| pri_lo_oe | output | 1 | Primary low port output enable |
| pri_hi_out | output | 8 | Primary high port value |
| sec_lo_out | output | 8 | Secondary low port drive value |
| sec_lo_oe | output | 1 | Secondary low port output enable |
| sec_hi_out | output | 8 | Secondary high port value |
| opcode | output | 8 | Last latched opcode byte |
| opcode_vld | output | 1 | Opcode latched in the previous clock |

## Verification
The assertions assume that `data_rd` and `data_wr` are never high together; one of them checks this on the inputs. They also assume the straps hold steady across a core cycle, because routing follows them directly. The bench changes straps and request inputs only on the falling edge inside phase 11, just ahead of the capture edge. It never asks for a read and a write in the same cycle. It counts strobe-low and latch-high phases over each whole cycle and compares those counts, the port bytes and the opcode with an independent routing model.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   localparam int ADDR_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      PAIR_NONE = 2'd0,
      PAIR_PRI  = 2'd1,
      PAIR_SEC  = 2'd2
   } pair_e;

   typedef struct packed {
      logic [ADDR_W-1:0] faddr;
      logic              rd;
      logic              wr;
      logic [ADDR_W-1:0] daddr;
      logic [BYTE_W-1:0] wdata;
   } cyc_t;

   // code bus chosen for one fetch address
   function automatic pair_e route_fetch(input logic bs, input logic ea,
                                         input logic [ADDR_W-1:0] a,
                                         input logic [ADDR_W-1:0] lim);
      if (!ea)
         return bs ? PAIR_SEC : PAIR_PRI;
      else if (!bs)
         return PAIR_NONE;
      else
         return (a < lim) ? PAIR_SEC : PAIR_PRI;
   endfunction
endpackage

// File: rtl/dbf_timer.sv
module dbf_timer
   import dbf_pkg::*;
#(
   parameter int PHASES = 12,
   parameter int PW     = $clog2(PHASES)
) (
   input  logic          clk,
   input  logic          rst,
   input  cyc_t          req,
   output logic [PW-1:0] phase,
   output cyc_t          cyc
);
   localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= '0;
         cyc   <= '0;
      end else if (phase == LAST) begin
         phase <= '0;
         cyc   <= req;
      end else begin
         phase <= phase + PW'(1);
      end
   end

   // R1
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      (phase != LAST) |=> (phase == $past(phase) + PW'(1)));
   // R1
   phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (phase == LAST) |=> (phase == '0));
   // R1
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      phase <= LAST);
endmodule

// File: rtl/dbf_strobe.sv
module dbf_strobe
   import dbf_pkg::*;
#(
   parameter int                PHASES  = 12,
   parameter int                ALE_LEN = 2,
   parameter int                STB_LEN = 3,
   parameter logic [ADDR_W-1:0] LIMIT   = 16'h2000,
   parameter int                PW      = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              idle,
   input  logic              bus_sel,
   input  logic              ext_acc,
   input  logic [PW-1:0]     phase,
   input  logic [ADDR_W-1:0] cyc_faddr,
   input  logic              cyc_rd,
   input  logic              cyc_wr,
   output logic              ale,
   output logic              psen_pri_n,
   output logic              psen_sec_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic              slot,
   output logic              in_ale,
   output logic              stb_last,
   output logic              data_cyc,
   output pair_e             slot_pair,
   output logic [ADDR_W-1:0] slot_addr
);
   localparam int            HALF   = PHASES / 2;
   localparam logic [PW-1:0] HALF_P = PW'(HALF);
   localparam logic [PW-1:0] ALE_P  = PW'(ALE_LEN);
   localparam logic [PW-1:0] SEND_P = PW'(ALE_LEN + STB_LEN);
   localparam logic [PW-1:0] SLST_P = PW'(ALE_LEN + STB_LEN - 1);
   localparam logic [PW-1:0] DLO_P  = PW'(ALE_LEN + 1);
   localparam logic [PW-1:0] DHI_P  = PW'(PHASES - ALE_LEN - 1);

   logic [PW-1:0] sp;
   logic          in_stb;
   logic          quiet;
   logic          dstb;

   assign quiet     = rst | idle;
   assign slot      = (phase >= HALF_P);
   assign sp        = slot ? (phase - HALF_P) : phase;
   assign in_ale    = (sp < ALE_P);
   assign in_stb    = (sp >= ALE_P) && (sp < SEND_P);
   assign stb_last  = (sp == SLST_P);
   assign data_cyc  = cyc_rd | cyc_wr;
   assign slot_addr = slot ? (cyc_faddr + ADDR_W'(1)) : cyc_faddr;
   assign slot_pair = data_cyc ? PAIR_NONE
                               : route_fetch(bus_sel, ext_acc, slot_addr, LIMIT);
   assign dstb      = (phase >= DLO_P) && (phase <= DHI_P);

   assign ale        = quiet | (in_ale & ~(data_cyc & slot));
   assign psen_pri_n = ~(~quiet & in_stb & (slot_pair == PAIR_PRI));
   assign psen_sec_n = ~(~quiet & in_stb & (slot_pair == PAIR_SEC));
   assign rd_n       = ~(~quiet & cyc_rd & dstb);
   assign wr_n       = ~(~quiet & cyc_wr & dstb);

   // R4
   psen_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!psen_pri_n && !psen_sec_n));
   // R7
   invalid_nostb_chk: assert property (@(posedge clk) disable iff (rst)
      (!bus_sel && ext_acc) |-> (psen_pri_n && psen_sec_n));
   // R3
   data_nopsen_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !wr_n) |-> (psen_pri_n && psen_sec_n && !ale));
   // R3
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n));
   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      idle |-> (ale && psen_pri_n && psen_sec_n && rd_n && wr_n));
endmodule

// File: rtl/dbf_ports.sv
module dbf_ports
   import dbf_pkg::*;
#(
   parameter int PHASES  = 12,
   parameter int ALE_LEN = 2,
   parameter int STB_LEN = 3,
   parameter int PW      = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              idle,
   input  logic              bus_sel,
   input  logic [PW-1:0]     phase,
   input  logic              slot,
   input  logic              in_ale,
   input  logic              stb_last,
   input  logic              data_cyc,
   input  pair_e             slot_pair,
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic              cyc_wr,
   input  logic [ADDR_W-1:0] cyc_daddr,
   input  logic [BYTE_W-1:0] cyc_wdata,
   input  logic              io_we,
   input  logic [BYTE_W-1:0] io_lo_d,
   input  logic [BYTE_W-1:0] io_hi_d,
   input  logic [BYTE_W-1:0] pri_lo_in,
   input  logic [BYTE_W-1:0] sec_lo_in,
   output logic [BYTE_W-1:0] pri_lo_out,
   output logic              pri_lo_oe,
   output logic [BYTE_W-1:0] pri_hi_out,
   output logic [BYTE_W-1:0] sec_lo_out,
   output logic              sec_lo_oe,
   output logic [BYTE_W-1:0] sec_hi_out,
   output logic [BYTE_W-1:0] opcode,
   output logic              opcode_vld
);
   localparam logic [BYTE_W-1:0] ONES   = '1;
   localparam logic [PW-1:0]     VLD0_P = PW'(ALE_LEN + STB_LEN);
   localparam logic [PW-1:0]     VLD1_P = PW'(PHASES / 2 + ALE_LEN + STB_LEN);

   logic              quiet;
   logic              f_act [2];
   logic              f_oe  [2];
   logic [BYTE_W-1:0] f_lo  [2];
   logic [BYTE_W-1:0] f_hi  [2];
   logic [BYTE_W-1:0] io_lo_q;
   logic [BYTE_W-1:0] io_hi_q;

   assign quiet = rst | idle;

   // fetch-driven values for each pair: 0 primary, 1 secondary
   for (genvar g = 0; g < 2; g++) begin : g_pair
      localparam pair_e ME = (g == 0) ? PAIR_PRI : PAIR_SEC;
      assign f_act[g] = ~quiet & (slot_pair == ME);
      assign f_oe[g]  = f_act[g] & in_ale;
      assign f_lo[g]  = f_act[g] ? slot_addr[BYTE_W-1:0]      : ONES;
      assign f_hi[g]  = f_act[g] ? slot_addr[ADDR_W-1:BYTE_W] : ONES;
   end

   always_comb begin
      if (!quiet && data_cyc) begin
         pri_hi_out = cyc_daddr[ADDR_W-1:BYTE_W];
         if (!slot && in_ale) begin
            pri_lo_out = cyc_daddr[BYTE_W-1:0];
            pri_lo_oe  = 1'b1;
         end else if (cyc_wr) begin
            pri_lo_out = cyc_wdata;
            pri_lo_oe  = 1'b1;
         end else begin
            pri_lo_out = ONES;
            pri_lo_oe  = 1'b0;
         end
      end else begin
         pri_lo_out = f_lo[0];
         pri_lo_oe  = f_oe[0];
         pri_hi_out = f_hi[0];
      end
   end

   always_comb begin
      if (!bus_sel) begin
         sec_lo_out = io_lo_q;
         sec_lo_oe  = 1'b1;
         sec_hi_out = io_hi_q;
      end else begin
         sec_lo_out = f_lo[1];
         sec_lo_oe  = f_oe[1];
         sec_hi_out = f_hi[1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         io_lo_q <= ONES;
         io_hi_q <= ONES;
      end else if (io_we) begin
         io_lo_q <= io_lo_d;
         io_hi_q <= io_hi_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         opcode     <= '0;
         opcode_vld <= 1'b0;
      end else begin
         opcode_vld <= 1'b0;
         if (stb_last && (f_act[0] || f_act[1])) begin
            opcode     <= f_act[1] ? sec_lo_in : pri_lo_in;
            opcode_vld <= 1'b1;
         end
      end
   end

   // R2
   opvld_phase_chk: assert property (@(posedge clk) disable iff (rst)
      opcode_vld |-> (phase == VLD0_P || phase == VLD1_P));
   // R8
   data_sec_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (data_cyc && bus_sel) |-> !sec_lo_oe);
endmodule

// File: rtl/dbfetch_seq.sv
module dbfetch_seq
   import dbf_pkg::*;
#(
   parameter int                PHASES    = 12,
   parameter int                ALE_LEN   = 2,
   parameter int                STB_LEN   = 3,
   parameter logic [ADDR_W-1:0] SEC_LIMIT = 16'h2000,
   parameter int                PW        = $clog2(PHASES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_sel,
   input  logic              ext_acc,
   input  logic              idle,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              data_rd,
   input  logic              data_wr,
   input  logic [ADDR_W-1:0] data_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              io_we,
   input  logic [BYTE_W-1:0] io_lo_d,
   input  logic [BYTE_W-1:0] io_hi_d,
   input  logic [BYTE_W-1:0] pri_lo_in,
   input  logic [BYTE_W-1:0] sec_lo_in,
   output logic [PW-1:0]     phase,
   output logic              ale,
   output logic              psen_pri_n,
   output logic              psen_sec_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [BYTE_W-1:0] pri_lo_out,
   output logic              pri_lo_oe,
   output logic [BYTE_W-1:0] pri_hi_out,
   output logic [BYTE_W-1:0] sec_lo_out,
   output logic              sec_lo_oe,
   output logic [BYTE_W-1:0] sec_hi_out,
   output logic [BYTE_W-1:0] opcode,
   output logic              opcode_vld
);
   if (PHASES % 2 != 0) begin : g_bad_odd
      $error("phase count must be even");
   end
   if (ALE_LEN < 1 || STB_LEN < 1) begin : g_bad_len
      $error("latch and strobe lengths must be at least one phase");
   end
   if (ALE_LEN + STB_LEN >= PHASES / 2) begin : g_bad_fit
      $error("latch plus strobe must fit inside half a cycle");
   end
   if (PW < $clog2(PHASES)) begin : g_bad_pw
      $error("phase width too small");
   end

   cyc_t              req;
   cyc_t              cyc;
   logic              slot;
   logic              in_ale;
   logic              stb_last;
   logic              data_cyc;
   pair_e             slot_pair;
   logic [ADDR_W-1:0] slot_addr;

   assign req = '{faddr: fetch_addr, rd: data_rd, wr: data_wr,
                  daddr: data_addr, wdata: wr_data};

   dbf_timer #(.PHASES(PHASES), .PW(PW)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .req   (req),
      .phase (phase),
      .cyc   (cyc)
   );

   dbf_strobe #(.PHASES(PHASES), .ALE_LEN(ALE_LEN), .STB_LEN(STB_LEN),
                .LIMIT(SEC_LIMIT), .PW(PW)) u_strobe (
      .clk        (clk),
      .rst        (rst),
      .idle       (idle),
      .bus_sel    (bus_sel),
      .ext_acc    (ext_acc),
      .phase      (phase),
      .cyc_faddr  (cyc.faddr),
      .cyc_rd     (cyc.rd),
      .cyc_wr     (cyc.wr),
      .ale        (ale),
      .psen_pri_n (psen_pri_n),
      .psen_sec_n (psen_sec_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .slot       (slot),
      .in_ale     (in_ale),
      .stb_last   (stb_last),
      .data_cyc   (data_cyc),
      .slot_pair  (slot_pair),
      .slot_addr  (slot_addr)
   );

   dbf_ports #(.PHASES(PHASES), .ALE_LEN(ALE_LEN), .STB_LEN(STB_LEN),
               .PW(PW)) u_ports (
      .clk        (clk),
      .rst        (rst),
      .idle       (idle),
      .bus_sel    (bus_sel),
      .phase      (phase),
      .slot       (slot),
      .in_ale     (in_ale),
      .stb_last   (stb_last),
      .data_cyc   (data_cyc),
      .slot_pair  (slot_pair),
      .slot_addr  (slot_addr),
      .cyc_wr     (cyc.wr),
      .cyc_daddr  (cyc.daddr),
      .cyc_wdata  (cyc.wdata),
      .io_we      (io_we),
      .io_lo_d    (io_lo_d),
      .io_hi_d    (io_hi_d),
      .pri_lo_in  (pri_lo_in),
      .sec_lo_in  (sec_lo_in),
      .pri_lo_out (pri_lo_out),
      .pri_lo_oe  (pri_lo_oe),
      .pri_hi_out (pri_hi_out),
      .sec_lo_out (sec_lo_out),
      .sec_lo_oe  (sec_lo_oe),
      .sec_hi_out (sec_hi_out),
      .opcode     (opcode),
      .opcode_vld (opcode_vld)
   );

   // R3
   req_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(data_rd && data_wr));
endmodule

// File: tb/dbfetch_seq_test.sv
module dbfetch_seq_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_sel = 1'b0, ext_acc = 1'b0, idle = 1'b0;
   logic [15:0] fetch_addr = 16'h0, data_addr = 16'h0;
   logic        data_rd = 1'b0, data_wr = 1'b0;
   logic [7:0]  wr_data = 8'h0;
   logic        io_we = 1'b0;
   logic [7:0]  io_lo_d = 8'h0, io_hi_d = 8'h0;
   logic [7:0]  pri_lo_in = 8'hA5, sec_lo_in = 8'h5A;
   logic [3:0]  phase;
   logic        ale, psen_pri_n, psen_sec_n, rd_n, wr_n;
   logic [7:0]  pri_lo_out, pri_hi_out, sec_lo_out, sec_hi_out, opcode;
   logic        pri_lo_oe, sec_lo_oe, opcode_vld;

   int errs = 0;
   int checks = 0;

   always #2 clk = ~clk;

   dbfetch_seq uut (
      .clk(clk), .rst(rst), .bus_sel(bus_sel), .ext_acc(ext_acc), .idle(idle),
      .fetch_addr(fetch_addr), .data_rd(data_rd), .data_wr(data_wr),
      .data_addr(data_addr), .wr_data(wr_data), .io_we(io_we),
      .io_lo_d(io_lo_d), .io_hi_d(io_hi_d), .pri_lo_in(pri_lo_in),
      .sec_lo_in(sec_lo_in), .phase(phase), .ale(ale),
      .psen_pri_n(psen_pri_n), .psen_sec_n(psen_sec_n), .rd_n(rd_n),
      .wr_n(wr_n), .pri_lo_out(pri_lo_out), .pri_lo_oe(pri_lo_oe),
      .pri_hi_out(pri_hi_out), .sec_lo_out(sec_lo_out),
      .sec_lo_oe(sec_lo_oe), .sec_hi_out(sec_hi_out), .opcode(opcode),
      .opcode_vld(opcode_vld)
   );

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // 0 none, 1 primary, 2 secondary
   function automatic int exp_pair(input logic bs, input logic ea,
                                   input logic [15:0] a);
      if (!ea) return bs ? 2 : 1;
      if (!bs) return 0;
      return (a < 16'h2000) ? 2 : 1;
   endfunction

   // one core cycle: load the request in phase 11, then watch all 12 phases
   task automatic go_cycle(input string req, input logic bs, input logic ea,
                           input logic idl, input logic [15:0] fa,
                           input logic rd, input logic wr,
                           input logic [15:0] da, input logic [7:0] wd);
      int ep [2];
      logic [15:0] sa [2];
      int ale_c = 0, pp_c = 0, ps_c = 0, rd_c = 0, wr_c = 0, vld_c = 0;
      int exp_pp = 0, exp_ps = 0, exp_vld = 0;
      while (phase != 4'd11) @(negedge clk);
      bus_sel = bs; ext_acc = ea; idle = idl; fetch_addr = fa;
      data_rd = rd; data_wr = wr; data_addr = da; wr_data = wd;
      sa[0] = fa;
      sa[1] = fa + 16'd1;
      for (int s = 0; s < 2; s++) begin
         ep[s] = (rd || wr || idl) ? 0 : exp_pair(bs, ea, sa[s]);
         if (ep[s] == 1) exp_pp += 3;
         if (ep[s] == 2) exp_ps += 3;
         if (ep[s] != 0) exp_vld++;
      end
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (k == 0 || k == 11) chk("R1", "phase", phase, k);
         ale_c += ale;
         pp_c  += !psen_pri_n;
         ps_c  += !psen_sec_n;
         rd_c  += !rd_n;
         wr_c  += !wr_n;
         vld_c += opcode_vld;
         for (int s = 0; s < 2; s++) begin
            if (k == 6 * s && ep[s] == 1) begin
               chk(req, "pri lo addr", pri_lo_out, sa[s][7:0]);
               chk(req, "pri lo oe", pri_lo_oe, 1);
               chk(req, "pri hi addr", pri_hi_out, sa[s][15:8]);
            end
            if (k == 6 * s && ep[s] == 2) begin
               chk(req, "sec lo addr", sec_lo_out, sa[s][7:0]);
               chk(req, "sec lo oe", sec_lo_oe, 1);
               chk(req, "sec hi addr", sec_hi_out, sa[s][15:8]);
            end
            if (k == 6 * s + 5 && ep[s] != 0) begin
               chk("R2", "opcode_vld", opcode_vld, 1);
               chk("R2", "opcode", opcode, (ep[s] == 2) ? sec_lo_in : pri_lo_in);
            end
         end
         if ((rd || wr) && !idl) begin
            if (k == 0) begin
               chk("R8", "data lo addr", pri_lo_out, da[7:0]);
               chk("R8", "data lo oe", pri_lo_oe, 1);
               chk("R8", "data hi addr", pri_hi_out, da[15:8]);
            end
            if (k == 5) begin
               chk("R3", "data lo oe", pri_lo_oe, wr ? 1 : 0);
               if (wr) chk("R3", "write data", pri_lo_out, wd);
               if (bs) chk("R8", "sec lo oe in data", sec_lo_oe, 0);
            end
         end
         if (idl && bs && k == 3) chk("R11", "sec hi idle", sec_hi_out, 8'hFF);
      end
      chk(idl ? "R11" : ((rd || wr) ? "R3" : "R1"), "ale phases", ale_c,
          idl ? 12 : ((rd || wr) ? 2 : 4));
      chk(req, "psen_pri low phases", pp_c, exp_pp);
      chk(req, "psen_sec low phases", ps_c, exp_ps);
      chk(req, "opcode_vld count", vld_c, exp_vld);
      chk("R3", "rd_n low phases", rd_c, (rd && !idl) ? 7 : 0);
      chk("R3", "wr_n low phases", wr_c, (wr && !idl) ? 7 : 0);
   endtask

   task automatic t_reset;
      int pp = 0;
      @(negedge clk);
      chk("R10", "phase in reset", phase, 0);
      chk("R10", "ale in reset", ale, 1);
      chk("R10", "psen_pri in reset", psen_pri_n, 1);
      chk("R10", "psen_sec in reset", psen_sec_n, 1);
      chk("R10", "rd_n/wr_n in reset", {rd_n, wr_n}, 2'b11);
      chk("R9", "sec lo reset", sec_lo_out, 8'hFF);
      chk("R9", "sec hi reset", sec_hi_out, 8'hFF);
      rst = 1'b0;
      #1;
      for (int k = 0; k < 12; k++) begin
         if (k > 0) @(negedge clk);
         pp += !psen_pri_n;
         if (k == 0) chk("R10", "first fetch lo", pri_lo_out, 8'h00);
         if (k == 6) chk("R10", "second fetch lo", pri_lo_out, 8'h01);
         if (k == 6) chk("R10", "second fetch hi", pri_hi_out, 8'h00);
      end
      chk("R10", "first cycle psen_pri phases", pp, 6);
   endtask

   task automatic t_io;
      @(negedge clk);
      bus_sel = 1'b0;
      io_we = 1'b1; io_lo_d = 8'h3C; io_hi_d = 8'hC3;
      @(negedge clk);
      io_we = 1'b0; io_lo_d = 8'h00; io_hi_d = 8'h00;
      chk("R9", "sec lo reg", sec_lo_out, 8'h3C);
      chk("R9", "sec hi reg", sec_hi_out, 8'hC3);
      chk("R9", "sec lo oe", sec_lo_oe, 1);
      @(negedge clk);
      chk("R9", "sec lo held", sec_lo_out, 8'h3C);
   endtask

   initial begin
      #(4 * 200000);
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      go_cycle("R4", 1'b0, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R5", 1'b1, 1'b0, 1'b0, 16'h8000, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R5", 1'b1, 1'b0, 1'b0, 16'h0040, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R6", 1'b1, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R6", 1'b1, 1'b1, 1'b0, 16'h3000, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R6", 1'b1, 1'b1, 1'b0, 16'h1FFF, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R7", 1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R3", 1'b1, 1'b1, 1'b0, 16'h0200, 1'b0, 1'b1, 16'hABCD, 8'h3C);
      go_cycle("R8", 1'b1, 1'b0, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h1F00, 8'h00);
      go_cycle("R8", 1'b0, 1'b0, 1'b0, 16'h0200, 1'b1, 1'b0, 16'h7E81, 8'h00);
      go_cycle("R11", 1'b1, 1'b0, 1'b1, 16'h0300, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R11", 1'b1, 1'b0, 1'b1, 16'h0300, 1'b0, 1'b1, 16'h4444, 8'h55);
      t_io();
      go_cycle("R5", 1'b1, 1'b0, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0, 8'h0);
      go_cycle("R4", 1'b0, 1'b0, 1'b0, 16'h2000, 1'b0, 1'b0, 16'h0, 8'h0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule